// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer peripheral with two byte-wide registers: a control/status register and an up-counter register. While running, a prescaler divides the system clock by a power of two chosen through a 3-bit divider-select field, and each prescaler period advances the 8-bit counter by one. When the counter wraps from 255 to 0, the block raises an overflow flag. If watchdog mode is selected, the wrap also drives a reset pulse out of the block and records that a reset took place.

Software uses the block by choosing a divider and mode while the timer is stopped, then setting the run bit. It keeps a healthy system alive by rewriting the counter before it wraps. A counter write also restarts the prescaler, so a full prescaler period always passes before the next count. Status flags stay set until software writes zero to them, and hardware setting a flag wins over a clear in the same cycle.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control register reads 0x07 (stopped, interval mode, both flags clear, divider code 7), the counter reads 0, and `wdtReset` is low.
- R2: Address 0 holds the control register, laid out as bit 7 run, bit 6 watchdog mode, bit 5 overflow flag, bit 4 reset status, bit 3 always 0 and bits 2:0 divider code. Address 1 holds the counter.
- R3: Divider code 5 advances the counter once every 2^BASE_LOG2 clocks, code 6 once every 2^(BASE_LOG2+1) clocks, and code 7 once every 2^(BASE_LOG2+2) clocks. The default BASE_LOG2=10 gives divisors of 1024, 2048 and 4096.
- R4: Writing a divider code from 0 to 4 while stopped stores code 7.
- R5: A control write made while the run bit is already set leaves the divider code unchanged.
- R6: Each counter wrap from 255 to 0 sets the overflow flag. Writing 1 to bit 5 leaves the flag unchanged, and writing 0 to bit 5 clears it.
- R7: In watchdog mode a wrap drives `wdtReset` high for exactly RST_CYCLES (16) clock cycles. In interval mode a wrap never raises `wdtReset`, and it leaves the reset status at 0.
- R8: Clearing the run bit freezes both the counter and the prescaler. The counter keeps its value, and counting continues from that value once the run bit is set again.
- R9: A counter write loads the written value and clears the prescaler, so the next increment comes one full divider period after the write.
- R10: A wrap in watchdog mode sets the reset status bit. Only writing 0 to bit 4 clears it, and a wrap in the same cycle as that clear leaves both flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write address: 0 control, 1 counter |
| wrData | input | 8 | Write data |
| rdAddr | input | 1 | Read address: 0 control, 1 counter |
| rdData | output | 8 | Read data for the register at `rdAddr` |
| wdtReset | output | 1 | Reset pulse raised on a wrap in watchdog mode |

## Verification
The counting path is driven from a table of rows. Each row pairs a divider code with a start value of 254, 255, 240 or 0 and counts the clocks from the run-bit write until the overflow flag appears. Rows with the same start value and different codes tell the three divisors apart. Rows with different start values and the same code show that the counter steps once per prescaler period and wraps only at 255. Directed tests follow: counter writes made partway through a prescaler period, stopping in mid-count, writes of the divider code while running and of invalid codes, a watchdog-mode wrap with its pulse length, and a flag clear that lands exactly on the wrap edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_MIN = 3'd5;
  localparam logic [SEL_W-1:0] SEL_DEF = 3'd7;
  localparam logic ADDR_CSR = 1'b0;
  localparam logic ADDR_CNT = 1'b1;

  // Fields of a control-register write, gathered from the data bus
  typedef struct packed {
    logic             run;
    logic             mode;
    logic             ovf;
    logic             rsts;
    logic [SEL_W-1:0] sel;
  } csrFields_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             runEn;
    logic             cntLoad;
    logic             preClear;
    logic [SEL_W-1:0] divSel;
  } ctlStrobes_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [REG_W-1:0]  loadVal,
  output logic [REG_W-1:0]  cntVal,
  output logic              wrapEvt
);
  localparam int PRE_W = BASE_LOG2 + 2;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divMax;
  logic             tick;

  always_comb begin
    case (ctl.divSel)
      3'd5:    divMax = {2'b00, {BASE_LOG2{1'b1}}};
      3'd6:    divMax = {1'b0, {(BASE_LOG2 + 1){1'b1}}};
      default: divMax = {PRE_W{1'b1}};
    endcase
  end

  assign tick    = ctl.runEn && (preCnt == divMax);
  assign wrapEvt = tick && !ctl.cntLoad && (cntVal == {REG_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctl.preClear) begin
      preCnt <= '0;
    end else if (ctl.runEn) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (ctl.cntLoad) begin
      cntVal <= loadVal;
    end else if (tick) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runEn && !ctl.cntLoad) |=> $stable(cntVal));
  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> (cntVal == '0));
  // R9
  load_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntLoad |=> (cntVal == $past(loadVal)));
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  csrFields_t       wrCsr,
  input  logic             wrapEvt,
  output ctlStrobes_t      ctl,
  output logic [REG_W-1:0] csrVal,
  output logic             wdtReset
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic             runBit, modeBit, ovfBit, rstsBit;
  logic [SEL_W-1:0] selReg;
  logic [RC_W-1:0]  rstLeft;
  logic             csrWr, selWr;
  logic [SEL_W-1:0] selNext;

  assign csrWr   = wrEn && (wrAddr == ADDR_CSR);
  assign selWr   = csrWr && !runBit;
  assign selNext = (wrCsr.sel < SEL_MIN) ? SEL_DEF : wrCsr.sel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      modeBit <= 1'b0;
      selReg  <= SEL_DEF;
    end else if (csrWr) begin
      runBit  <= wrCsr.run;
      modeBit <= wrCsr.mode;
      if (selWr) selReg <= selNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfBit  <= 1'b0;
      rstsBit <= 1'b0;
    end else begin
      if (wrapEvt)                  ovfBit <= 1'b1;
      else if (csrWr && !wrCsr.ovf) ovfBit <= 1'b0;
      if (wrapEvt && modeBit)        rstsBit <= 1'b1;
      else if (csrWr && !wrCsr.rsts) rstsBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstLeft <= '0;
    end else if (wrapEvt && modeBit) begin
      rstLeft <= RC_W'(RST_CYCLES);
    end else if (rstLeft != '0) begin
      rstLeft <= rstLeft - 1'b1;
    end
  end

  assign wdtReset     = (rstLeft != '0);
  assign ctl.runEn    = runBit;
  assign ctl.cntLoad  = wrEn && (wrAddr == ADDR_CNT);
  assign ctl.preClear = ctl.cntLoad || selWr;
  assign ctl.divSel   = selReg;
  assign csrVal       = {runBit, modeBit, ovfBit, rstsBit, 1'b0, selReg};

  // R5
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && csrWr) |=> $stable(selReg));
  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfBit && !(csrWr && !wrCsr.ovf)) |=> ovfBit);
  // R7
  rst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && modeBit) |=> wdtReset);
  // R7
  no_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && !modeBit && !wdtReset) |=> !wdtReset);
  // R10
  rsts_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEvt && modeBit) |=> rstsBit);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2  = 10,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdAddr,
  output logic [REG_W-1:0] rdData,
  output logic             wdtReset
);
  ctlStrobes_t      ctl;
  csrFields_t       wrCsr;
  logic [REG_W-1:0] cntVal, csrVal;
  logic             wrapEvt;

  assign wrCsr = '{run: wrData[7], mode: wrData[6], ovf: wrData[5],
                   rsts: wrData[4], sel: wrData[2:0]};

  wdt_control #(.RST_CYCLES(RST_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCsr(wrCsr),
    .wrapEvt(wrapEvt), .ctl(ctl), .csrVal(csrVal), .wdtReset(wdtReset)
  );

  wdt_datapath #(.BASE_LOG2(BASE_LOG2)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadVal(wrData),
    .cntVal(cntVal), .wrapEvt(wrapEvt)
  );

  assign rdData = (rdAddr == ADDR_CNT) ? cntVal : csrVal;
endmodule

// File: tb/wdt_timer_tb_top.sv
`timescale 1ns/1ps
module wdt_timer_tb_top;
  localparam int B = 2;
  localparam int NROW = 6;
  localparam logic [7:0] SEL_T [NROW] = '{8'd5, 8'd6, 8'd7, 8'd6, 8'd7, 8'd5};
  localparam logic [7:0] CNT_T [NROW] = '{8'hFE, 8'hFE, 8'hF0, 8'h00, 8'hFF, 8'hFF};
  localparam int         EXP_T [NROW] = '{8, 16, 256, 2048, 16, 4};

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, wrAddr = 1'b0, rdAddr = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic wdtReset;
  int checks = 0, failures = 0, rstCycles = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (wdtReset) rstCycles <= rstCycles + 1;

  wdt_timer #(.BASE_LOG2(B), .RST_CYCLES(16)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wdtReset(wdtReset)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called and returns at a negedge; the write lands on the next posedge
  task automatic regWrite(input logic a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic a, output logic [7:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic stopSel(input logic [7:0] sel);
    regWrite(1'b0, 8'h07);
    regWrite(1'b0, sel);
  endtask

  // clock edges until the overflow flag is visible
  task automatic waitOvf(output int n);
    logic [7:0] v;
    n = 0;
    regRead(1'b0, v);
    while (!v[5] && n < 5000) begin
      @(negedge clk);
      n++;
      regRead(1'b0, v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, w;
    int n, r0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 reset state
    regRead(1'b0, v); chk("R1 csr", v, 8'h07);
    regRead(1'b1, v); chk("R1 cnt", v, 8'h00);
    chk("R1 wdtReset", wdtReset, 0);

    // R3 R6 R7 table of divider/start rows, interval mode
    for (int i = 0; i < NROW; i++) begin
      stopSel(SEL_T[i]);
      regWrite(1'b1, CNT_T[i]);
      r0 = rstCycles;
      regWrite(1'b0, 8'h80 | SEL_T[i]);
      waitOvf(n);
      chk("R3 period", n, EXP_T[i]);
      regRead(1'b0, v); chk("R6 R2 csr after wrap", v, 8'hA0 | SEL_T[i]);
      chk("R7 no reset in interval mode", rstCycles - r0, 0);
    end

    // R6 flag hold and clear
    regWrite(1'b0, 8'hA5);
    regRead(1'b0, v); chk("R6 write 1 keeps flag", v, 8'hA5);
    regWrite(1'b0, 8'h85);
    regRead(1'b0, v); chk("R6 write 0 clears flag", v, 8'h85);

    // R5 divider code locked while running
    regWrite(1'b0, 8'h86);
    regRead(1'b0, v); chk("R5 sel locked", v, 8'h85);

    // R4 invalid codes
    stopSel(8'h02);
    regRead(1'b0, v); chk("R4 code 2 -> 7", v, 8'h07);
    regWrite(1'b0, 8'h05);
    regRead(1'b0, v); chk("R4 code 5 kept", v, 8'h05);
    regWrite(1'b0, 8'h03);
    regRead(1'b0, v); chk("R4 code 3 -> 7", v, 8'h07);

    // R9 counter write clears prescaler (code 7: 16 clocks per count)
    regWrite(1'b1, 8'h00);
    regWrite(1'b0, 8'h87);
    repeat (7) @(negedge clk);
    regWrite(1'b1, 8'h10);
    n = 0;
    regRead(1'b1, v);
    while (v != 8'h11 && n < 100) begin
      @(negedge clk); n++; regRead(1'b1, v);
    end
    chk("R9 first step after load", n, 16);

    // R8 halt holds counter
    repeat (5) @(negedge clk);
    regWrite(1'b0, 8'h07);
    regRead(1'b1, v);
    repeat (100) @(negedge clk);
    regRead(1'b1, w); chk("R8 counter frozen", w, v);
    regRead(1'b0, w); chk("R8 csr stopped", w, 8'h07);
    regWrite(1'b0, 8'h87);
    repeat (17) @(negedge clk);
    regRead(1'b1, w); chk("R8 resumes", w, v + 8'd1);

    // R7 R10 watchdog mode pulse
    stopSel(8'h05);
    regWrite(1'b1, 8'hFF);
    r0 = rstCycles;
    regWrite(1'b0, 8'hC5);
    waitOvf(n);
    chk("R3 watchdog period", n, 4);
    chk("R7 reset high at wrap", wdtReset, 1);
    regRead(1'b0, v); chk("R10 R2 csr flags", v, 8'hF5);
    repeat (40) @(negedge clk);
    chk("R7 pulse length", rstCycles - r0, 16);
    regWrite(1'b0, 8'hC5);
    regRead(1'b0, v); chk("R10 flags cleared", v, 8'hC5);

    // R10 clear on the wrap edge: hardware set wins
    stopSel(8'h05);
    regWrite(1'b1, 8'hFF);
    regWrite(1'b0, 8'hC5);
    repeat (3) @(negedge clk);
    regWrite(1'b0, 8'hC5);
    regRead(1'b0, v); chk("R10 set beats clear", v, 8'hF5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule